// File: doc/BRIEF.md
# Program Counter Fetch Unit

This unit keeps the instruction address of a small 16-bit processor. It holds the program counter and always presents the next sequential address. It is one of two masters on a shared memory address bus and read line. The controller broadcasts a state code every cycle. The counter changes only in the advance state. In that state it takes either a branch target supplied from outside or the incremented value. Branch evaluation happens elsewhere and arrives as a single taken flag.

Three of the controller's states belong to the load/store path: data read, data write and pointer read. During those states the unit floats both the address lines and the read line so that the other master can use the bus. In all other states it drives the current counter value and holds the read line high. The state codes are shared with the controller through a common package.

Top module: `fetch_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the counter is loaded with 16'h3000, and that value is visible on `addr_io` after reset is released in a driven state.
- R2: `npc_o` always equals the counter plus one, modulo 2^16.
- R3: The counter changes only at an edge where `state_i` is 4'd9 (advance). In every other state it holds, whatever `br_taken_i` and `taddr_i` are.
- R4: At an advance edge the counter loads `taddr_i` when `br_taken_i` is 1, and loads `npc_o` when `br_taken_i` is 0.
- R5: While `state_i` is 4'd5 (pointer read), 4'd6 (data read) or 4'd7 (data write), `addr_io` and `rd_io` are high impedance, so another master's values appear on the bus without contention.
- R6: In every other state code, including the unused codes 4'd10 to 4'd15, `addr_io` carries the counter and `rd_io` is driven to 1.
- R7: Sequential advance from 16'hFFFF wraps the counter to 16'h0000.
- R8: Reset takes priority over an advance-state load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| state_i | input | 4 | Controller state code |
| br_taken_i | input | 1 | Selects the branch target at the advance edge |
| taddr_i | input | 16 | Branch target address |
| addr_io | inout | 16 | Shared address bus; counter value or released |
| rd_io | inout | 1 | Shared read line; 1 or released |
| npc_o | output | 16 | Counter plus one |

## Verification
The counter load and the bus drive happen together in the advance state. In that cycle the bus must still show the old counter, and the new value must show only after the edge. The bench follows each advance with a driven state and compares the bus value before and after the edge. A second case puts reset in the same cycle as an advance with a taken branch, and the counter must come out at the reset value. During the three load/store states the bench's own master drives a distinct pattern on the bus. If the unit fails to release the bus, the resolved value is corrupted.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
    localparam int ADDR_W  = 16;
    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH   = 4'd0,
        ST_DECODE  = 4'd1,
        ST_ALU     = 4'd2,
        ST_TARGET  = 4'd3,
        ST_ADDR    = 4'd4,
        ST_PTR_RD  = 4'd5,
        ST_DATA_RD = 4'd6,
        ST_DATA_WR = 4'd7,
        ST_REG_WB  = 4'd8,
        ST_ADVANCE = 4'd9
    } ctrl_state_e;

    function automatic logic bus_released(input logic [STATE_W-1:0] s);
        return (s == ST_PTR_RD) || (s == ST_DATA_RD) || (s == ST_DATA_WR);
    endfunction
endpackage

// File: rtl/fetch_pc_core.sv
module fetch_pc_core
    import fetch_pkg::*;
#(
    parameter int                 W        = ADDR_W,
    parameter logic [W-1:0]       RESET_PC = 16'h3000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STATE_W-1:0] state_i,
    input  logic               br_taken_i,
    input  logic [W-1:0]       taddr_i,
    output logic [W-1:0]       pc_o,
    output logic [W-1:0]       npc_o
);
    typedef struct packed {
        logic [W-1:0] pc;
    } core_regs_t;

    core_regs_t regs_d, regs_q;
    logic [W-1:0] inc_w;

    always_comb begin
        inc_w  = regs_q.pc + W'(1);
        regs_d = regs_q;
        if (rst) begin
            regs_d.pc = RESET_PC;
        end else if (state_i == ST_ADVANCE) begin
            regs_d.pc = br_taken_i ? taddr_i : inc_w;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign pc_o  = regs_q.pc;
    assign npc_o = inc_w;

    // R1 / R8: reset wins and yields the start address
    p_reset_load_r1: assert property (@(posedge clk)
        rst |=> (pc_o == RESET_PC));

    // R3: outside the advance state the counter holds
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (state_i != ST_ADVANCE) |=> $stable(pc_o));

    // R4: taken branch loads the target
    p_branch_r4: assert property (@(posedge clk) disable iff (rst)
        (state_i == ST_ADVANCE && br_taken_i) |=> (pc_o == $past(taddr_i)));

    // R4 / R7: sequential advance loads the previous next-address
    p_seq_r7: assert property (@(posedge clk) disable iff (rst)
        (state_i == ST_ADVANCE && !br_taken_i) |=> (pc_o == $past(npc_o)));
endmodule

// File: rtl/fetch_bus_port.sv
module fetch_bus_port
    import fetch_pkg::*;
#(
    parameter int W = ADDR_W
) (
    input  logic [STATE_W-1:0] state_i,
    input  logic [W-1:0]       pc_i,
    output logic               drive_o,
    inout  wire  [W-1:0]       addr_io,
    inout  wire                rd_io
);
    always_comb begin
        drive_o = !bus_released(state_i);
    end

    assign addr_io = drive_o ? pc_i : {W{1'bz}};
    assign rd_io   = drive_o ? 1'b1 : 1'bz;

    // R5 / R6: drive follows the state code at every instant
    always_comb begin
        if (state_i == ST_DATA_WR) begin
            p_release_r5: assert (!drive_o);
        end
        if (state_i == ST_ADVANCE) begin
            p_drive_r6: assert (drive_o);
        end
    end
endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
    import fetch_pkg::*;
#(
    parameter int                 W        = ADDR_W,
    parameter logic [W-1:0]       RESET_PC = 16'h3000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STATE_W-1:0] state_i,
    input  logic               br_taken_i,
    input  logic [W-1:0]       taddr_i,
    inout  wire  [W-1:0]       addr_io,
    inout  wire                rd_io,
    output logic [W-1:0]       npc_o
);
    logic [W-1:0] pc_w;
    logic         drive_w;

    fetch_pc_core #(.W(W), .RESET_PC(RESET_PC)) u_core (
        .clk       (clk),
        .rst       (rst),
        .state_i   (state_i),
        .br_taken_i(br_taken_i),
        .taddr_i   (taddr_i),
        .pc_o      (pc_w),
        .npc_o     (npc_o)
    );

    fetch_bus_port #(.W(W)) u_port (
        .state_i(state_i),
        .pc_i   (pc_w),
        .drive_o(drive_w),
        .addr_io(addr_io),
        .rd_io  (rd_io)
    );

    // R3: while the bus is released the counter cannot change
    p_released_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !drive_w |=> $stable(pc_w));
endmodule

// File: tb/fetch_unit_tb.sv
module fetch_unit_tb;
    localparam logic [15:0] OTHER_ADDR = 16'hA5C3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  state = 4'd0;
    logic        br = 1'b0;
    logic [15:0] taddr = 16'h0000;
    logic [15:0] npc;
    wire  [15:0] addr_bus;
    wire         rd_bus;
    logic        other_on;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [15:0] addr;
        logic        rd;
        logic [15:0] npc;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [15:0] pc_m = 16'h3000;

    always #4 clk = ~clk;

    assign other_on = (state == 4'd5) || (state == 4'd6) || (state == 4'd7);
    assign addr_bus = other_on ? OTHER_ADDR : 16'hzzzz;
    assign rd_bus   = other_on ? 1'b0 : 1'bz;

    fetch_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .state_i   (state),
        .br_taken_i(br),
        .taddr_i   (taddr),
        .addr_io   (addr_bus),
        .rd_io     (rd_bus),
        .npc_o     (npc)
    );

    task automatic step(input logic [3:0] s, input logic b, input logic [15:0] t,
                        input logic r, input string tag);
        exp_t e;
        @(negedge clk);
        state = s; br = b; taddr = t; rst = r;
        #2;
        e.addr = other_on ? OTHER_ADDR : pc_m;
        e.rd   = other_on ? 1'b0 : 1'b1;
        e.npc  = pc_m + 16'd1;
        e.tag  = tag;
        sb.push_back(e);
        if (r)             pc_m = 16'h3000;
        else if (s == 4'd9) pc_m = b ? t : pc_m + 16'd1;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #3;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (addr_bus !== e.addr) begin
                    errors++;
                    $display("FAIL %s addr actual %h expected %h", e.tag, addr_bus, e.addr);
                end
                checks++;
                if (rd_bus !== e.rd) begin
                    errors++;
                    $display("FAIL %s rd actual %b expected %b", e.tag, rd_bus, e.rd);
                end
                checks++;
                if (npc !== e.npc) begin
                    errors++;
                    $display("FAIL R2 npc actual %h expected %h", npc, e.npc);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : driver
        step(4'd0, 1'b0, 16'h0, 1'b1, "R1");
        step(4'd0, 1'b0, 16'h0, 1'b1, "R1");
        step(4'd0, 1'b0, 16'h0, 1'b0, "R1");
        // walk all state codes with branch inputs active: no change off advance
        for (int s = 0; s < 16; s++) begin
            if (s != 9)
                step(4'(s), 1'b1, 16'h1234, 1'b0,
                     (s >= 5 && s <= 7) ? "R5" : "R6_R3");
        end
        step(4'd1, 1'b0, 16'h0, 1'b0, "R3");
        // sequential advance then observe
        step(4'd9, 1'b0, 16'h7777, 1'b0, "R4_seq");
        step(4'd0, 1'b0, 16'h0, 1'b0, "R4_seq");
        // taken branch
        step(4'd9, 1'b1, 16'hFFFE, 1'b0, "R4_br");
        step(4'd2, 1'b0, 16'h0, 1'b0, "R4_br");
        step(4'd9, 1'b0, 16'h0, 1'b0, "R7");
        step(4'd8, 1'b0, 16'h0, 1'b0, "R7");
        step(4'd9, 1'b0, 16'h0, 1'b0, "R7");
        step(4'd0, 1'b0, 16'h0, 1'b0, "R7");
        step(4'd9, 1'b0, 16'h0, 1'b0, "R7");
        step(4'd6, 1'b1, 16'hBEEF, 1'b0, "R5");
        step(4'd7, 1'b0, 16'h0, 1'b0, "R5");
        step(4'd1, 1'b0, 16'h0, 1'b0, "R7_R3");
        // back-to-back advances with alternating choice
        for (int i = 0; i < 6; i++)
            step(4'd9, i[0], 16'h4000 + 16'(i * 3), 1'b0, "R4");
        step(4'd3, 1'b0, 16'h0, 1'b0, "R4");
        // reset together with a taken advance
        step(4'd9, 1'b1, 16'h5555, 1'b1, "R8");
        step(4'd0, 1'b0, 16'h0, 1'b0, "R8");
        step(4'd5, 1'b0, 16'h0, 1'b0, "R5");
        step(4'd4, 1'b0, 16'h0, 1'b0, "R8");
        @(negedge clk);
        @(negedge clk);
        #5;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule